// File: doc/BRIEF.md
# Lenient Speculative Conditional Select

This block evaluates the conditional assignment y = (x > 0) ? -x : b*x as a small pipelined dataflow circuit with valid/ready handshakes on every channel. Two operand channels, x and b, feed the block. Each x value is paired with one b value, and the pair enters two branch operators at the same moment. A one-cycle stage produces the predicate (x > 0) together with -x. A three-stage pipelined multiplier produces b*x. Both branches run speculatively, before the predicate is known.

A lenient selector sends each result to a registered output channel. When the predicate is true, it emits -x as soon as the short path has delivered, without waiting for the multiplier. The product belonging to that token is still taken out of the multiplier when it arrives and is then dropped. A debt counter records how many such products are still to be dropped, so each later product is matched with its own predicate. Results therefore leave in input order. The latency follows the branch that is taken, not the slower of the two.

All arithmetic is 16-bit two's complement and wraps: -(-32768) gives -32768, and the product is the low 16 bits of b*x.

Top module: `lenient_cond_select`

## Requirements
- R1: While reset is high, and afterwards until a pair has been accepted, y_valid is low.
- R2: An x transfer (x_valid and x_ready both high) happens in exactly the same cycles as a b transfer, and the n-th x is paired with the n-th b.
- R3: For an accepted pair whose x is positive as a signed 16-bit value, the result is the 16-bit two's complement negation of x. For example, x = 32767 gives 0x8001.
- R4: For an accepted pair whose x is zero or negative, the result is the low 16 bits of x*b. For example, x = 0 gives 0 and x = -32768 with b = 1 gives 0x8000.
- R5: On an idle block with y_ready held high, a pair accepted at a rising edge with positive x shows y_valid in the cycle after the next rising edge. With x zero or negative, y_valid shows three rising edges later. The positive case is therefore 2 cycles sooner.
- R6: Exactly one result leaves on y for each accepted pair, in the order the pairs were accepted, under any pattern of input gaps and output back-pressure. Products dropped after a positive predicate never appear on y and never shift later results.
- R7: While y_valid is high and y_ready is low, y_valid stays high and y_data keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_valid | input | 1 | x channel holds a value |
| x_ready | output | 1 | Block takes the x value this cycle when x_valid is high |
| x_data | input | 16 | Signed operand x |
| b_valid | input | 1 | b channel holds a value |
| b_ready | output | 1 | Block takes the b value this cycle when b_valid is high |
| b_data | input | 16 | Signed operand b |
| y_valid | output | 1 | Result register holds a value |
| y_ready | input | 1 | Consumer takes the result this cycle |
| y_data | output | 16 | Signed result |

## Verification
The assertions assume that the x and b producers keep their data and valid steady until a transfer takes place. They also assume that the consumer may lower y_ready at any time, without this ever causing a value to be lost. The stimulus updates an operand only in the cycle after that operand's transfer, or while its valid is low. It changes y_ready randomly on every cycle. The x values are biased towards the sign boundary (0, 1, -1) and the wrap corners (32767, -32768). This mixes taken and dropped products against a busy multiplier and pushes the debt counter towards its limit.

// File: rtl/lsel_pkg.sv
package lsel_pkg;
  localparam int DEF_WIDTH   = 16;
  localparam int DEF_MUL_LAT = 3;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_NEG  = 2'd1,
    PICK_MUL  = 2'd2
  } pick_t;
endpackage

// File: rtl/lsel_neg_stage.sv
module lsel_neg_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_x,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_pred,
  output logic [WIDTH-1:0] out_neg
);
  logic             vld_q;
  logic             pred_q;
  logic [WIDTH-1:0] neg_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_pred  = pred_q;
  assign out_neg   = neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      pred_q <= 1'b0;
      neg_q  <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        pred_q <= ($signed(in_x) > $signed({WIDTH{1'b0}}));
        neg_q  <= (~in_x) + {{(WIDTH-1){1'b0}}, 1'b1};
      end
    end
  end

  AST_NEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_neg) && $stable(out_pred))); // R3
endmodule

// File: rtl/lsel_mul_pipe.sv
module lsel_mul_pipe #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_p
);
  localparam int PW = 2 * WIDTH;

  logic [STAGES-1:0] vld_q;
  logic [STAGES:0]   adv;
  logic [WIDTH-1:0]  a_q, b_q;
  logic [WIDTH-1:0]  prod_q [STAGES];
  logic [PW-1:0]     full_prod;

  assign adv[STAGES] = out_ready;
  assign full_prod   = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q};

  // stage 0 latches the operands
  assign adv[0] = !vld_q[0] || adv[1];
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (adv[0]) begin
      vld_q[0] <= in_valid;
      if (in_valid) begin
        a_q <= in_a;
        b_q <= in_b;
      end
    end
  end
  assign prod_q[0] = '0;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign adv[s] = !vld_q[s] || adv[s+1];
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[s]  <= 1'b0;
        prod_q[s] <= '0;
      end else if (adv[s]) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) begin
          if (s == 1) prod_q[s] <= full_prod[WIDTH-1:0];
          else        prod_q[s] <= prod_q[s-1];
        end
      end
    end
  end

  assign in_ready  = adv[0];
  assign out_valid = vld_q[STAGES-1];
  assign out_p     = prod_q[STAGES-1];

  AST_MUL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p))); // R6
  AST_MUL_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> vld_q[0]); // R6
endmodule

// File: rtl/lsel_select.sv
module lsel_select
  import lsel_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MUL_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             n_valid,
  output logic             n_ready,
  input  logic             n_pred,
  input  logic [WIDTH-1:0] n_neg,
  input  logic             m_valid,
  output logic             m_ready,
  input  logic [WIDTH-1:0] m_prod,
  output logic             y_valid,
  input  logic             y_ready,
  output logic [WIDTH-1:0] y_data
);
  localparam int DW = $clog2(MUL_LAT + 2);
  localparam logic [DW-1:0] DEBT_MAX = DW'(MUL_LAT);

  pick_t           pick;
  logic [DW-1:0]   debt_q;
  logic            out_free;
  logic            drop_old;
  logic            head_pair;
  logic            debt_inc;
  logic            yv_q;
  logic [WIDTH-1:0] yd_q;

  assign out_free  = !yv_q || y_ready;
  // a waiting product with no debt belongs to the token at the head of the short path
  assign head_pair = m_valid && (debt_q == '0);
  assign drop_old  = m_valid && (debt_q != '0);

  always_comb begin
    pick = PICK_NONE;
    if (n_valid && out_free) begin
      if (n_pred)         pick = PICK_NEG;
      else if (head_pair) pick = PICK_MUL;
    end
  end

  assign n_ready  = (pick != PICK_NONE);
  assign m_ready  = drop_old || (pick == PICK_MUL) || ((pick == PICK_NEG) && head_pair);
  assign debt_inc = (pick == PICK_NEG) && !head_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
    end else begin
      case ({debt_inc, drop_old})
        2'b10:   debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yv_q <= 1'b0;
      yd_q <= '0;
    end else if (pick != PICK_NONE) begin
      yv_q <= 1'b1;
      yd_q <= (pick == PICK_NEG) ? n_neg : m_prod;
    end else if (y_ready) begin
      yv_q <= 1'b0;
    end
  end

  assign y_valid = yv_q;
  assign y_data  = yd_q;

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data))); // R7
  AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (rst)
    debt_q <= DEBT_MAX); // R6
  AST_DEBT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (m_valid && debt_q == '0) |-> n_valid); // R6
  AST_DROP_DONE: assert property (@(posedge clk) disable iff (rst)
    (drop_old && !debt_inc) |=> (debt_q == $past(debt_q) - 1'b1)); // R6
endmodule

// File: rtl/lenient_cond_select.sv
module lenient_cond_select
  import lsel_pkg::*;
#(
  parameter int WIDTH   = DEF_WIDTH,
  parameter int MUL_LAT = DEF_MUL_LAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             x_valid,
  output logic             x_ready,
  input  logic [WIDTH-1:0] x_data,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [WIDTH-1:0] b_data,
  output logic             y_valid,
  input  logic             y_ready,
  output logic [WIDTH-1:0] y_data
);
  logic             neg_in_rdy, mul_in_rdy, both_rdy, pair_go;
  logic             n_valid, n_ready, n_pred;
  logic [WIDTH-1:0] n_neg;
  logic             m_valid, m_ready;
  logic [WIDTH-1:0] m_prod;

  assign both_rdy = neg_in_rdy && mul_in_rdy;
  assign x_ready  = b_valid && both_rdy;
  assign b_ready  = x_valid && both_rdy;
  assign pair_go  = x_valid && b_valid && both_rdy;

  lsel_neg_stage #(.WIDTH(WIDTH)) neg_i (
    .clk(clk), .rst(rst),
    .in_valid(pair_go), .in_ready(neg_in_rdy), .in_x(x_data),
    .out_valid(n_valid), .out_ready(n_ready),
    .out_pred(n_pred), .out_neg(n_neg)
  );

  lsel_mul_pipe #(.WIDTH(WIDTH), .STAGES(MUL_LAT)) mul_i (
    .clk(clk), .rst(rst),
    .in_valid(pair_go), .in_ready(mul_in_rdy), .in_a(x_data), .in_b(b_data),
    .out_valid(m_valid), .out_ready(m_ready), .out_p(m_prod)
  );

  lsel_select #(.WIDTH(WIDTH), .MUL_LAT(MUL_LAT)) sel_i (
    .clk(clk), .rst(rst),
    .n_valid(n_valid), .n_ready(n_ready), .n_pred(n_pred), .n_neg(n_neg),
    .m_valid(m_valid), .m_ready(m_ready), .m_prod(m_prod),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
  );

  AST_PAIR_JOIN: assert property (@(posedge clk) disable iff (rst)
    (x_valid && x_ready) |-> (b_valid && b_ready)); // R2
  AST_SHORT_FILL: assert property (@(posedge clk) disable iff (rst)
    (x_valid && x_ready) |=> n_valid); // R5
endmodule

// File: tb/lenient_cond_select_tb.sv
module lenient_cond_select_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_valid = 1'b0, b_valid = 1'b0, y_ready = 1'b0;
  logic [W-1:0] x_data = '0, b_data = '0;
  logic x_ready, b_ready, y_valid;
  logic [W-1:0] y_data;

  always #5 clk = ~clk;

  lenient_cond_select dut_i (
    .clk(clk), .rst(rst),
    .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] xq[$], bq[$], expq[$];
  bit xf, bf, yv_seen, hold_pend;
  logic [W-1:0] hold_val;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] xv, logic [W-1:0] bv);
    logic [2*W-1:0] p;
    if ($signed(xv) > 0) return (~xv) + 1'b1;   // R3
    p = {{W{1'b0}}, xv} * {{W{1'b0}}, bv};       // R4
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] pick_x();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'h0001;
      3: return 16'hFFFF;
      4: return 16'h7FFF;
      default: return W'($urandom);
    endcase
  endfunction

  task automatic monitor();
    xf = x_valid && x_ready;
    bf = b_valid && b_ready;
    if (xf || bf) chk(xf == bf, "R2", "x/b transfer mismatch", int'(xf), int'(bf));
    if (xf) xq.push_back(x_data);
    if (bf) bq.push_back(b_data);
    while (xq.size() > 0 && bq.size() > 0) expq.push_back(model(xq.pop_front(), bq.pop_front()));
    if (hold_pend) begin
      chk(y_valid && y_data == hold_val, "R7", "stalled output changed", int'(y_data), int'(hold_val));
      hold_pend = 0;
    end
    if (y_valid && !y_ready) begin
      hold_pend = 1;
      hold_val  = y_data;
    end
    yv_seen = y_valid;
    if (y_valid && y_ready) begin
      if (expq.size() == 0) chk(0, "R6", "extra output", int'(y_data), 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(y_data == e, "R6", "result or order", int'(y_data), int'(e));
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    monitor();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    x_valid = 0; b_valid = 0; y_ready = 1;
    repeat (n) cycle();
  endtask

  task automatic latency(logic [W-1:0] xv, logic [W-1:0] bv, int exp_lat, string req);
    int lat;
    idle(10);
    x_data = xv; b_data = bv; x_valid = 1; b_valid = 1;
    cycle();
    chk(xf, req, "pair not accepted on idle block", int'(xf), 1);
    x_valid = 0; b_valid = 0;
    lat = 0;
    do begin
      cycle();
      lat++;
    end while (!yv_seen && lat < 20);
    chk(lat == exp_lat, req, "output latency", lat, exp_lat);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(y_valid == 0, "R1", "y_valid during reset", int'(y_valid), 0);
    @(posedge clk); #1;
    rst = 0;
    repeat (3) cycle();
    chk(y_valid == 0, "R1", "y_valid before any input", int'(y_valid), 0);

    // R5: short path and long path latency on idle block
    latency(16'd5, 16'd3, 2, "R5");
    latency(16'hFFFB, 16'd3, 4, "R5");
    latency(16'h0000, 16'd9, 4, "R5");
    // R3 / R4 directed corners
    latency(16'h7FFF, 16'd2, 2, "R3");
    latency(16'h8000, 16'd1, 4, "R4");

    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      cycle();
      if (!x_valid || xf) begin
        x_valid = ($urandom % 4) != 0;
        x_data  = pick_x();
      end
      if (!b_valid || bf) begin
        b_valid = ($urandom % 4) != 0;
        b_data  = W'($urandom);
      end
      y_ready = ($urandom % 3) != 0;
    end
    // dense burst of positive x behind a stalled multiplier result
    for (int i = 0; i < 400; i++) begin
      cycle();
      if (!x_valid || xf) begin x_valid = 1; x_data = (i % 5 == 0) ? 16'hFFF0 : 16'd7; end
      if (!b_valid || bf) begin b_valid = 1; b_data = W'(i); end
      y_ready = (i % 7) != 3;
    end
    idle(30);
    chk(expq.size() == 0 && xq.size() == 0 && bq.size() == 0, "R6", "results left undelivered",
        expq.size(), 0);
    chk(y_valid == 0, "R6", "output valid after drain", int'(y_valid), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule